// File: doc/BRIEF.md
# Masked-Write Dual-Bank GPIO Port

This block is a 32-pin general-purpose I/O port controlled through a plain register bus. The pins form two 16-pin banks: pins 15:0 and pins 31:16. Each bank has a direction register and an output-value register. A single read-only input register returns the synchronised pad levels for all 32 pins. The block drives an output-enable vector and an output-value vector toward the pad ring, and it samples the raw pad inputs.

Every write to a bank register carries its own write-enable mask. The upper half of the bus word selects which bits change, and the lower half supplies their new values. Firmware can therefore set or clear any subset of pins in one bus cycle, with no read-modify-write. Reads are combinational from the presented offset. Writes take effect at the clock edge on which `bus_wr` is sampled high.

The bus is a control path, so it has no handshake. A write completes in one cycle, and read data is valid while the offset is held.

Top module: `gpio_dual_bank_port`

## Requirements
- R1: After reset, both direction registers hold zero, so `pad_oe` is all zeros. The output registers hold `OUT_INIT`: bits 15:0 in the low bank and bits 31:16 in the high bank.
- R2: A write to a direction register uses `bus_wdata[31:16]` as a mask and `bus_wdata[15:0]` as the data. Only bits whose mask bit is 1 take the data value, and the change is visible after that clock edge. Offset 0x6108 selects the low bank and offset 0x610C selects the high bank.
- R3: A write to an output-value register follows the same mask rule. Offset 0x6100 selects the low bank and offset 0x6104 selects the high bank.
- R4: A write to one bank never changes the other bank's direction or output value.
- R5: `pad_oe` equals the two direction registers: the low bank on pins 15:0 and the high bank on pins 31:16. `pad_out` carries the stored output value where `pad_oe` is 1 and 0 where `pad_oe` is 0.
- R6: Reading any of the four bank registers returns its 16 stored bits in bits 15:0, with bits 31:16 equal to zero.
- R7: Reading offset 0x0000 returns `pad_in` after a two-flop synchroniser. A pad change is first visible after the second rising clock edge.
- R8: A write to any offset other than the four bank registers changes nothing. This includes the input register at 0x0000. A read from any offset other than the five mapped ones returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register offset from the port base |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 32 | Write word: mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_oe | output | 32 | Output enable per pin, 1 = driven |
| pad_out | output | 32 | Output level per pin, 0 where not driven |

## Verification
The synchroniser property assumes that `pad_in` holds each value for at least one full clock cycle. It compares the input register with the pad value sampled two edges earlier. The bench therefore changes `pad_in` only on falling edges and holds it across the sampling edges. The write properties assume that `bus_wr` and `bus_addr` are stable around the rising edge. The bench drives them from falling edges only, and drives random masks and data toward both mapped and unmapped offsets.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [15:0] OFF_INPUT = 16'h0000;
  localparam logic [15:0] OFF_OUT_LO = 16'h6100;
  localparam logic [15:0] OFF_OUT_HI = 16'h6104;
  localparam logic [15:0] OFF_DIR_LO = 16'h6108;
  localparam logic [15:0] OFF_DIR_HI = 16'h610C;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_INPUT,
    SEL_OUT,
    SEL_DIR
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     bank;
  } reg_hit_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  always_comb begin
    hit = '{sel: SEL_NONE, bank: 1'b0};
    if (addr == ADDR_W'(OFF_INPUT))       hit = '{sel: SEL_INPUT, bank: 1'b0};
    else if (addr == ADDR_W'(OFF_OUT_LO)) hit = '{sel: SEL_OUT,   bank: 1'b0};
    else if (addr == ADDR_W'(OFF_OUT_HI)) hit = '{sel: SEL_OUT,   bank: 1'b1};
    else if (addr == ADDR_W'(OFF_DIR_LO)) hit = '{sel: SEL_DIR,   bank: 1'b0};
    else if (addr == ADDR_W'(OFF_DIR_HI)) hit = '{sel: SEL_DIR,   bank: 1'b1};
  end
endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
  parameter int          W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= INIT;
    else if (wr_en) q <= (q & ~wmask) | (wdata & wmask);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_dual_bank_port.sv
module gpio_dual_bank_port
  import gpio_port_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [31:0] OUT_INIT = 32'hA5A5_0F0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_oe,
  output logic [31:0]       pad_out
);
  localparam int BANK_W    = 16;
  localparam int NUM_BANKS = 2;
  localparam int PIN_W     = BANK_W * NUM_BANKS;

  reg_hit_t           hit;
  logic [PIN_W-1:0]   in_sync;
  logic [BANK_W-1:0]  dir_q [NUM_BANKS];
  logic [BANK_W-1:0]  out_q [NUM_BANKS];
  logic [BANK_W-1:0]  wmask;
  logic [BANK_W-1:0]  wdata;

  assign wmask = bus_wdata[2*BANK_W-1:BANK_W];
  assign wdata = bus_wdata[BANK_W-1:0];

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .hit  (hit)
  );

  gpio_in_sync #(.W(PIN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic dir_we;
    logic out_we;
    assign dir_we = bus_wr && (hit.sel == SEL_DIR) && (hit.bank == 1'(b));
    assign out_we = bus_wr && (hit.sel == SEL_OUT) && (hit.bank == 1'(b));

    gpio_masked_reg #(.W(BANK_W), .INIT('0)) u_dir (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (dir_we),
      .wmask (wmask),
      .wdata (wdata),
      .q     (dir_q[b])
    );

    gpio_masked_reg #(.W(BANK_W), .INIT(OUT_INIT[b*BANK_W +: BANK_W])) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (out_we),
      .wmask (wmask),
      .wdata (wdata),
      .q     (out_q[b])
    );

    assign pad_oe[b*BANK_W +: BANK_W]  = dir_q[b];
    assign pad_out[b*BANK_W +: BANK_W] = out_q[b] & dir_q[b];
  end

  always_comb begin
    bus_rdata = '0;
    case (hit.sel)
      SEL_INPUT: bus_rdata = in_sync;
      SEL_OUT:   bus_rdata[BANK_W-1:0] = out_q[hit.bank];
      SEL_DIR:   bus_rdata[BANK_W-1:0] = dir_q[hit.bank];
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_dual_bank_port_chk.sv
module gpio_dual_bank_port_chk
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       pad_in,
  input logic [31:0]       pad_oe,
  input logic [31:0]       pad_out
);
  logic [1:0] since_rst;
  logic       is_bank_reg;
  logic       is_mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  assign is_bank_reg = (bus_addr == ADDR_W'(OFF_OUT_LO)) || (bus_addr == ADDR_W'(OFF_OUT_HI)) ||
                       (bus_addr == ADDR_W'(OFF_DIR_LO)) || (bus_addr == ADDR_W'(OFF_DIR_HI));
  assign is_mapped   = is_bank_reg || (bus_addr == ADDR_W'(OFF_INPUT));

  // R2
  dir_lo_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_DIR_LO)) |=>
      pad_oe[15:0] == (($past(pad_oe[15:0]) & ~$past(bus_wdata[31:16])) |
                       ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

  // R2
  dir_hi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_DIR_HI)) |=>
      pad_oe[31:16] == (($past(pad_oe[31:16]) & ~$past(bus_wdata[31:16])) |
                        ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

  // R4
  lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADDR_W'(OFF_DIR_LO) || bus_addr == ADDR_W'(OFF_OUT_LO))) |=>
      ($stable(pad_oe[31:16]) && $stable(pad_out[31:16])));

  // R4
  hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADDR_W'(OFF_DIR_HI) || bus_addr == ADDR_W'(OFF_OUT_HI))) |=>
      ($stable(pad_oe[15:0]) && $stable(pad_out[15:0])));

  // R5
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == 32'h0);

  // R6
  readback_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_bank_reg |-> bus_rdata[31:16] == 16'h0);

  // R7
  input_two_flop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2 && bus_addr == ADDR_W'(OFF_INPUT)) |-> bus_rdata == $past(pad_in, 2));

  // R8
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !is_bank_reg) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped |-> bus_rdata == 32'h0);
endmodule

bind gpio_dual_bank_port gpio_dual_bank_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out)
);

// File: tb/gpio_dual_bank_port_test.sv
module gpio_dual_bank_port_test;
  localparam logic [31:0] INIT = 32'hA5A5_0F0F;
  localparam logic [15:0] A_IN = 16'h0000, A_OL = 16'h6100, A_OH = 16'h6104,
                          A_DL = 16'h6108, A_DH = 16'h610C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = 32'h1234_5678;
  logic [31:0] pad_oe;
  logic [31:0] pad_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] m_dir [2];
  logic [15:0] m_out [2];
  logic [31:0] m_in;

  always #4 clk = ~clk;

  gpio_dual_bank_port #(.ADDR_W(16), .OUT_INIT(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    case (a)
      A_IN: return m_in;
      A_OL: return {16'h0, m_out[0]};
      A_OH: return {16'h0, m_out[1]};
      A_DL: return {16'h0, m_dir[0]};
      A_DH: return {16'h0, m_dir[1]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [31:0] w);
    case (a)
      A_OL: m_out[0] = merge(m_out[0], w);
      A_OH: m_out[1] = merge(m_out[1], w);
      A_DL: m_dir[0] = merge(m_dir[0], w);
      A_DH: m_dir[1] = merge(m_dir[1], w);
      default: ;
    endcase
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] w);
    @(negedge clk);
    bus_addr = a; bus_wdata = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, w);
  endtask

  task automatic check_read(input string req, input logic [15:0] a);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic check_pads(input string req);
    chk(req, pad_oe, {m_dir[1], m_dir[0]});
    chk(req, pad_out, {m_out[1] & m_dir[1], m_out[0] & m_dir[0]});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [4];
    addrs[0] = A_OL; addrs[1] = A_OH; addrs[2] = A_DL; addrs[3] = A_DH;
    m_dir[0] = '0; m_dir[1] = '0;
    m_out[0] = INIT[15:0]; m_out[1] = INIT[31:16];
    m_in = 32'h1234_5678;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_pads("R1");
    check_read("R1", A_OL);
    check_read("R1", A_OH);
    check_read("R1", A_DL);
    check_read("R1", A_DH);

    // R2 masked direction write, low bank
    bus_write(A_DL, 32'hFFFF_00FF);
    check_pads("R2"); check_read("R2", A_DL);
    bus_write(A_DL, 32'h0F0F_FFF0);
    check_pads("R2"); check_read("R2", A_DL);
    // R2 zero mask changes nothing
    bus_write(A_DL, 32'h0000_FFFF);
    check_pads("R2"); check_read("R2", A_DL);

    // R3 masked output write, then R4 independence via high bank
    bus_write(A_OL, 32'hF0F0_AAAA);
    check_pads("R3"); check_read("R3", A_OL);
    bus_write(A_DH, 32'hFFFF_FFFF);
    check_pads("R4"); check_read("R4", A_DL); check_read("R4", A_DH);
    bus_write(A_OH, 32'h00FF_0000);
    check_pads("R4"); check_read("R4", A_OL); check_read("R5", A_OH);

    // R6 readback upper half zero after full-width data
    bus_write(A_OH, 32'hFFFF_1234);
    check_read("R6", A_OH);

    // R8 unmapped and input-offset writes ignored, unmapped read zero
    bus_write(16'h6110, 32'hFFFF_FFFF);
    check_pads("R8");
    bus_write(A_IN, 32'hFFFF_0000);
    check_pads("R8");
    check_read("R8", 16'h6110);
    check_read("R8", 16'h6102);
    check_read("R8", A_IN);

    // R7 two-flop latency
    @(negedge clk);
    pad_in = 32'hCAFE_F00D;
    bus_addr = A_IN;
    @(negedge clk); #1;
    chk("R7", bus_rdata, 32'h1234_5678);
    @(negedge clk); #1;
    chk("R7", bus_rdata, 32'hCAFE_F00D);
    m_in = 32'hCAFE_F00D;

    // R2 R3 R4 R5 R8 random traffic
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      logic [31:0] w;
      w = $urandom;
      if (($urandom % 8) == 0) a = 16'($urandom) | 16'h0001;
      else a = addrs[$urandom % 4];
      bus_write(a, w);
      check_pads("R5");
      check_read("R6", addrs[$urandom % 4]);
    end

    // R7 random pad values
    for (int i = 0; i < 20; i++) begin
      logic [31:0] v;
      v = $urandom;
      @(negedge clk);
      pad_in = v;
      bus_addr = A_IN;
      @(negedge clk); @(negedge clk); #1;
      chk("R7", bus_rdata, v);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule